// File: doc/BRIEF.md
# Multi-Block Erase Scheduler

This block collects a list of memory blocks to be erased and then runs the erase one block at a time. A command decoder sends it a select pulse with a block index for every block the user names. The first select opens a selection window; every later select inside the window adds its block and restarts the window. When the window runs out with no new select, the erase begins. From that point the list is closed.

The scheduler masks the list with the per-block protection bits at the moment the erase begins. Protected blocks are left out and raise no error. It then drives one erase request at a time to an array model, in ascending block order, and waits for a done pulse for each block. If every listed block is protected, the scheduler stays busy for a fixed dummy interval and then returns to idle without touching the array. A suspend pulse has two effects. In the window it parks the operation at once. During the erase it stops the request and reports suspended after a fixed settling interval. A resume pulse restarts the work. The interrupted block is issued again, and the window, if it had not yet expired, is cut short. A done pulse can flag a failure. Failures are gathered in a bitmap, and the scheduler holds an error state until a read/reset command arrives.

Top module: `erase_sched`

## Requirements
- R1: After reset, busy_o, started_o, suspended_o, error_o and erase_req_o are 0 and fail_map_o is all zeros.
- R2: A select pulse in idle opens the window: from the next cycle busy_o is 1 and started_o is 0. It also clears fail_map_o.
- R3: Each select sampled in the window restarts it. started_o becomes 1 exactly WINDOW_CYC clock edges after the edge that sampled the last select, and not earlier.
- R4: Once started_o is 1, select pulses are ignored, and the named block is never requested in this operation.
- R5: Blocks that were selected and unprotected when the erase began are requested one at a time, lowest index first. erase_req_o stays 1 with erase_idx_o fixed until erase_done_i is sampled, and protected blocks are never requested.
- R6: If every selected block is protected, busy_o and started_o stay 1 for EMPTY_CYC cycles with erase_req_o at 0. Then busy_o returns to 0 with error_o 0. A suspend pulse in this phase has no effect.
- R7: A suspend pulse during an erase (without a done pulse in the same cycle) drops erase_req_o on the next cycle. suspended_o rises SUSPEND_CYC edges after the suspend edge, with busy_o 0. A resume pulse then re-issues the same block on the next cycle.
- R8: A suspend pulse in the window sets suspended_o on the next cycle. The erase does not start while suspended, whatever time passes. A resume pulse starts it on the next cycle, and selects made while suspended are dropped.
- R9: An erase may be suspended and resumed any number of times, and it still erases each unprotected selected block exactly once.
- R10: A done pulse with erase_fail_i at 1 sets the fail_map_o bit of the current block. After the last block, error_o is 1 and busy_o is 0. error_o holds until reset_cmd_i is sampled, which returns the block to idle.
- R11: With no failure, busy_o and started_o fall on the cycle after the last done pulse, and error_o stays 0. reset_cmd_i outside the error state has no effect.
- R12: erase_done_i is ignored while erase_req_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_pulse_i | input | 1 | Add the block named by sel_idx_i to the list |
| sel_idx_i | input | $clog2(NUM_BLOCKS) | Block index for a select pulse |
| suspend_i | input | 1 | Suspend request pulse |
| resume_i | input | 1 | Resume request pulse |
| reset_cmd_i | input | 1 | Read/reset command pulse; clears the error state |
| protect_i | input | NUM_BLOCKS | Per-block protection bits |
| erase_done_i | input | 1 | Array reports the current block finished |
| erase_fail_i | input | 1 | Qualifies erase_done_i: the block failed |
| erase_req_o | output | 1 | Erase request to the array |
| erase_idx_o | output | $clog2(NUM_BLOCKS) | Block being erased |
| busy_o | output | 1 | Window open, erase running, settling or dummy phase |
| started_o | output | 1 | Erase phase has begun; the list is closed |
| suspended_o | output | 1 | Operation parked by a suspend |
| error_o | output | 1 | A block failed; waiting for read/reset |
| fail_map_o | output | NUM_BLOCKS | Blocks that failed in the current operation |

## Verification
Random lists of one to four blocks are selected with random gaps below the window length. These are combined with random protection masks and failure masks, so each run compares the ascending request order, the skip of protected blocks and the failure bitmap against a bench model. Some runs insert suspend and resume pairs at random points in the erase. These tell whether the interrupted block is re-issued rather than dropped or repeated. Late selects after the start check that the list is closed. Directed cases cover three situations that random runs do not reach with exact timing: a fully protected list, which separates the dummy interval from a real erase; a suspend inside the window, which separates an immediate park from a delayed start; and a stray done or reset command in states where it must do nothing.

// File: rtl/erase_sched_pkg.sv
package erase_sched_pkg;

   typedef enum logic [2:0] {
      ES_IDLE     = 3'd0,
      ES_WINDOW   = 3'd1,
      ES_WIN_HOLD = 3'd2,
      ES_ERASE    = 3'd3,
      ES_HALTING  = 3'd4,
      ES_HALTED   = 3'd5,
      ES_HOLLOW   = 3'd6,
      ES_FAULT    = 3'd7
   } es_state_t;

   function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/esch_timer.sv
module esch_timer #(
   parameter int unsigned CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart_i,
   input  logic [CW-1:0] limit_i,
   output logic          expire_o
);
   logic [CW-1:0] cnt_q;

   assign expire_o = (cnt_q == (limit_i - CW'(1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (restart_i)
         cnt_q <= '0;
      else if (!expire_o)
         cnt_q <= cnt_q + CW'(1);
   end
endmodule

// File: rtl/esch_pick.sv
module esch_pick #(
   parameter int unsigned NB        = 8,
   parameter bit          LOW_FIRST = 1'b1,
   localparam int unsigned IW       = $clog2(NB)
) (
   input  logic [NB-1:0] req_i,
   output logic [IW-1:0] idx_o,
   output logic          any_o
);
   assign any_o = |req_i;

   generate
      if (LOW_FIRST) begin : g_low
         always_comb begin
            idx_o = '0;
            for (int i = NB - 1; i >= 0; i--)
               if (req_i[i]) idx_o = IW'(i);
         end
      end else begin : g_high
         always_comb begin
            idx_o = '0;
            for (int i = 0; i < NB; i++)
               if (req_i[i]) idx_o = IW'(i);
         end
      end
   endgenerate
endmodule

// File: rtl/erase_sched.sv
module erase_sched
   import erase_sched_pkg::*;
#(
   parameter int unsigned NUM_BLOCKS  = 8,
   parameter int unsigned WINDOW_CYC  = 5000,
   parameter int unsigned EMPTY_CYC   = 10000,
   parameter int unsigned SUSPEND_CYC = 1500,
   parameter bit          LOW_FIRST   = 1'b1,
   localparam int unsigned IW         = $clog2(NUM_BLOCKS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sel_pulse_i,
   input  logic [IW-1:0]         sel_idx_i,
   input  logic                  suspend_i,
   input  logic                  resume_i,
   input  logic                  reset_cmd_i,
   input  logic [NUM_BLOCKS-1:0] protect_i,
   input  logic                  erase_done_i,
   input  logic                  erase_fail_i,
   output logic                  erase_req_o,
   output logic [IW-1:0]         erase_idx_o,
   output logic                  busy_o,
   output logic                  started_o,
   output logic                  suspended_o,
   output logic                  error_o,
   output logic [NUM_BLOCKS-1:0] fail_map_o
);
   localparam int unsigned NB   = NUM_BLOCKS;
   localparam int unsigned MAXC = max3(WINDOW_CYC, EMPTY_CYC, SUSPEND_CYC);
   localparam int unsigned CW   = $clog2(MAXC + 1);
   localparam logic [NB-1:0] ONE = NB'(1);

   generate
      if (NUM_BLOCKS < 2) begin : g_chk_nb
         $error("erase_sched: NUM_BLOCKS must be at least 2");
      end
      if (WINDOW_CYC < 1 || EMPTY_CYC < 1 || SUSPEND_CYC < 1) begin : g_chk_cyc
         $error("erase_sched: interval parameters must be at least 1");
      end
   endgenerate

   es_state_t     st_q, st_d;
   logic [NB-1:0] sel_q, sel_d, pend_q, pend_d, fail_q, fail_d;
   logic [NB-1:0] sel_hot, cur_hot, clean_list;
   logic [IW-1:0] pick_idx;
   logic          pick_any;
   logic          launch;
   logic          tmr_restart, tmr_exp;
   logic [CW-1:0] tmr_limit;

   esch_pick #(.NB(NB), .LOW_FIRST(LOW_FIRST)) u_pick (
      .req_i (pend_q),
      .idx_o (pick_idx),
      .any_o (pick_any)
   );

   always_comb begin
      case (st_q)
         ES_HOLLOW:  tmr_limit = CW'(EMPTY_CYC);
         ES_HALTING: tmr_limit = CW'(SUSPEND_CYC);
         default:    tmr_limit = CW'(WINDOW_CYC);
      endcase
   end

   esch_timer #(.CW(CW)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart_i (tmr_restart),
      .limit_i   (tmr_limit),
      .expire_o  (tmr_exp)
   );

   assign sel_hot    = ONE << sel_idx_i;
   assign cur_hot    = ONE << pick_idx;
   assign clean_list = sel_q & ~protect_i;

   always_comb begin
      st_d   = st_q;
      sel_d  = sel_q;
      pend_d = pend_q;
      fail_d = fail_q;
      launch = 1'b0;
      case (st_q)
         ES_IDLE: if (sel_pulse_i) begin
            st_d   = ES_WINDOW;
            sel_d  = sel_hot;
            fail_d = '0;
         end
         ES_WINDOW: begin
            if (sel_pulse_i) sel_d = sel_q | sel_hot;
            if (suspend_i)        st_d   = ES_WIN_HOLD;
            else if (!sel_pulse_i && tmr_exp) launch = 1'b1;
         end
         ES_WIN_HOLD: if (resume_i) launch = 1'b1;
         ES_ERASE: begin
            if (erase_done_i) begin
               pend_d = pend_q & ~cur_hot;
               if (erase_fail_i) fail_d = fail_q | cur_hot;
               if (pend_d == '0)  st_d = (fail_d != '0) ? ES_FAULT : ES_IDLE;
               else if (suspend_i) st_d = ES_HALTING;
            end else if (suspend_i) begin
               st_d = ES_HALTING;
            end
         end
         ES_HALTING: if (tmr_exp)     st_d = ES_HALTED;
         ES_HALTED:  if (resume_i)    st_d = ES_ERASE;
         ES_HOLLOW:  if (tmr_exp)     st_d = ES_IDLE;
         ES_FAULT:   if (reset_cmd_i) st_d = ES_IDLE;
         default:    st_d = ES_IDLE;
      endcase
      if (launch) begin
         pend_d = clean_list;
         st_d   = (clean_list != '0) ? ES_ERASE : ES_HOLLOW;
      end
   end

   assign tmr_restart = (st_d != st_q) || (st_q == ES_WINDOW && sel_pulse_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ES_IDLE;
         sel_q  <= '0;
         pend_q <= '0;
         fail_q <= '0;
      end else begin
         st_q   <= st_d;
         sel_q  <= sel_d;
         pend_q <= pend_d;
         fail_q <= fail_d;
      end
   end

   assign erase_req_o = (st_q == ES_ERASE) && pick_any;
   assign erase_idx_o = pick_idx;
   assign busy_o      = (st_q == ES_WINDOW) || (st_q == ES_ERASE) ||
                        (st_q == ES_HALTING) || (st_q == ES_HOLLOW);
   assign started_o   = (st_q == ES_ERASE) || (st_q == ES_HALTING) ||
                        (st_q == ES_HALTED) || (st_q == ES_HOLLOW);
   assign suspended_o = (st_q == ES_WIN_HOLD) || (st_q == ES_HALTED);
   assign error_o     = (st_q == ES_FAULT);
   assign fail_map_o  = fail_q;

   AST_LIST_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
      (started_o && sel_pulse_i) |=> $stable(sel_q)); // R4
   AST_REQ_LISTED: assert property (@(posedge clk) disable iff (!rst_n)
      erase_req_o |-> sel_q[erase_idx_o]); // R5
   AST_DONE_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
      (erase_req_o && erase_done_i) |=> !pend_q[$past(erase_idx_o)]); // R5
   AST_SUSP_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (erase_req_o && suspend_i && !erase_done_i) |=> !erase_req_o); // R7
   AST_WIN_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
      (suspended_o && !started_o && !resume_i) |=> !started_o); // R8
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (error_o && !reset_cmd_i) |=> error_o); // R10
endmodule

// File: tb/erase_sched_test.sv
`timescale 1ns/1ps
module erase_sched_test;
   localparam int NB    = 8;
   localparam int IW    = 3;
   localparam int WIN   = 12;
   localparam int EMPTY = 20;
   localparam int SUSP  = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sel_pulse_i = 1'b0, suspend_i = 1'b0, resume_i = 1'b0, reset_cmd_i = 1'b0;
   logic [IW-1:0] sel_idx_i = '0;
   logic [NB-1:0] protect_i = '0;
   logic erase_done_i = 1'b0, erase_fail_i = 1'b0;
   logic erase_req_o, busy_o, started_o, suspended_o, error_o;
   logic [IW-1:0] erase_idx_o;
   logic [NB-1:0] fail_map_o;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   erase_sched #(.NUM_BLOCKS(NB), .WINDOW_CYC(WIN), .EMPTY_CYC(EMPTY),
                 .SUSPEND_CYC(SUSP), .LOW_FIRST(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .sel_pulse_i(sel_pulse_i), .sel_idx_i(sel_idx_i),
      .suspend_i(suspend_i), .resume_i(resume_i), .reset_cmd_i(reset_cmd_i),
      .protect_i(protect_i), .erase_done_i(erase_done_i), .erase_fail_i(erase_fail_i),
      .erase_req_o(erase_req_o), .erase_idx_o(erase_idx_o), .busy_o(busy_o),
      .started_o(started_o), .suspended_o(suspended_o), .error_o(error_o),
      .fail_map_o(fail_map_o));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int low_bit(input logic [NB-1:0] m);
      for (int i = NB - 1; i >= 0; i--) if (m[i]) low_bit = i;
   endfunction

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_sel(input int idx);
      sel_pulse_i = 1'b1; sel_idx_i = IW'(idx);
      @(negedge clk);
      sel_pulse_i = 1'b0;
   endtask

   task automatic pulse_susp();
      suspend_i = 1'b1; @(negedge clk); suspend_i = 1'b0;
   endtask

   task automatic pulse_resume();
      resume_i = 1'b1; @(negedge clk); resume_i = 1'b0;
   endtask

   task automatic pulse_rst_cmd();
      reset_cmd_i = 1'b1; @(negedge clk); reset_cmd_i = 1'b0;
   endtask

   // Service the erase list; expects to be at a negedge with the erase phase running.
   task automatic service(input logic [NB-1:0] exp_list, input logic [NB-1:0] fails,
                          input bit do_susp);
      logic [NB-1:0] rem;
      int guard;
      rem = exp_list;
      guard = 0;
      while (rem != '0 && guard < 200) begin
         guard++;
         chk(erase_req_o === 1'b1, "R5 request", int'(erase_req_o), 1);
         chk(erase_idx_o == IW'(low_bit(rem)), "R5 order", int'(erase_idx_o), low_bit(rem));
         step($urandom % 3);
         if (do_susp && ($urandom % 2) == 0) begin
            pulse_susp();
            chk(erase_req_o == 1'b0, "R7 request drop", int'(erase_req_o), 0);
            step(SUSP - 1);
            chk(suspended_o == 1'b0, "R7 settle", int'(suspended_o), 0);
            step(1);
            chk(suspended_o == 1'b1 && busy_o == 1'b0, "R7 suspended", int'(suspended_o), 1);
            erase_done_i = 1'b1; @(negedge clk); erase_done_i = 1'b0; // R12 stray done
            pulse_resume();
            chk(erase_idx_o == IW'(low_bit(rem)), "R9 same block", int'(erase_idx_o), low_bit(rem));
         end else begin
            erase_done_i = 1'b1;
            erase_fail_i = fails[erase_idx_o];
            rem[erase_idx_o] = 1'b0;
            @(negedge clk);
            erase_done_i = 1'b0; erase_fail_i = 1'b0;
         end
      end
      chk(busy_o == 1'b0 && started_o == 1'b0, "R11 finish", int'(busy_o), 0);
      chk(fail_map_o == (fails & exp_list), "R10 fail map", int'(fail_map_o),
          int'(fails & exp_list));
      if ((fails & exp_list) != '0) begin
         chk(error_o == 1'b1, "R10 error set", int'(error_o), 1);
         step(3);
         chk(error_o == 1'b1, "R10 error held", int'(error_o), 1);
         pulse_rst_cmd();
         chk(error_o == 1'b0 && busy_o == 1'b0, "R10 cleared", int'(error_o), 0);
      end else begin
         chk(error_o == 1'b0, "R11 no error", int'(error_o), 0);
      end
   endtask

   task automatic trial(input int nsel, input logic [NB-1:0] prot,
                        input logic [NB-1:0] fails, input bit do_susp, input bit late);
      logic [NB-1:0] sel_map;
      int idx;
      sel_map = '0;
      protect_i = prot;
      for (int k = 0; k < nsel; k++) begin
         idx = $urandom % NB;
         sel_map[idx] = 1'b1;
         pulse_sel(idx);
         if (k == 0) chk(busy_o == 1'b1 && started_o == 1'b0 && fail_map_o == '0,
                         "R2 window open", int'(busy_o), 1);
         if (k < nsel - 1) step($urandom % (WIN - 1));
      end
      step(WIN - 1);
      chk(started_o == 1'b0, "R3 not yet", int'(started_o), 0);
      step(1);
      chk(started_o == 1'b1, "R3 started", int'(started_o), 1);
      if ((sel_map & ~prot) == '0) begin
         pulse_susp();
         step(EMPTY - 2);
         chk(busy_o == 1'b1 && erase_req_o == 1'b0 && suspended_o == 1'b0,
             "R6 dummy phase", int'(erase_req_o), 0);
         step(1);
         chk(busy_o == 1'b0 && error_o == 1'b0, "R6 dummy end", int'(busy_o), 0);
      end else begin
         if (late) pulse_sel(0); // R4 late select must be dropped
         service(sel_map & ~prot, fails, do_susp);
      end
   endtask

   initial begin
      void'($urandom(32'd1234));
      step(2);
      chk(busy_o == 1'b0 && started_o == 1'b0 && suspended_o == 1'b0 && error_o == 1'b0
          && erase_req_o == 1'b0 && fail_map_o == '0, "R1 reset", int'(busy_o), 0);
      rst_n = 1'b1;
      step(1);

      // R11 reset command and R12 done in idle do nothing
      pulse_rst_cmd();
      erase_done_i = 1'b1; @(negedge clk); erase_done_i = 1'b0;
      chk(busy_o == 1'b0 && error_o == 1'b0 && erase_req_o == 1'b0, "R11 idle rst cmd",
          int'(busy_o), 0);

      // R4 late select of block 0 while erasing blocks 1 and 3
      protect_i = '0;
      pulse_sel(3); pulse_sel(1);
      step(WIN);
      chk(started_o == 1'b1 && erase_idx_o == 3'd1, "R5 first block", int'(erase_idx_o), 1);
      pulse_sel(0);
      service(8'b0000_1010, 8'h00, 1'b0);

      // R6 all selected blocks protected
      trial(2, 8'hFF, 8'h00, 1'b0, 1'b0);

      // R8 suspend inside the window
      protect_i = '0;
      pulse_sel(2);
      step(3);
      pulse_susp();
      chk(suspended_o == 1'b1 && started_o == 1'b0, "R8 parked", int'(suspended_o), 1);
      pulse_sel(5);
      step(2 * WIN);
      chk(started_o == 1'b0 && suspended_o == 1'b1, "R8 no start", int'(started_o), 0);
      pulse_resume();
      chk(started_o == 1'b1 && erase_idx_o == 3'd2, "R8 resume start", int'(erase_idx_o), 2);
      service(8'b0000_0100, 8'h00, 1'b0);

      // R9 repeated suspends, R10 failure
      trial(4, 8'h00, 8'hFF, 1'b1, 1'b0);

      for (int t = 0; t < 40; t++) begin
         trial(1 + ($urandom % 4), NB'($urandom) & NB'($urandom),
               NB'($urandom) & NB'($urandom) & NB'($urandom),
               1'($urandom), ($urandom % 4) == 0);
         step($urandom % 3);
      end

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule